// File: doc/BRIEF.md
# Auto-baud serial debug receiver

This block is the receive front end of a single-wire asynchronous debug link that discovers its own bit rate. After reset it has no baud rate. It watches the idle-high line until the host sends its first character, which must be 0x80. The start bit and the seven low data bits of that character form one unbroken low pulse that lasts eight bit periods. The block counts that pulse in system clocks. It rejects counts that fall outside the supported range, and it keeps one eighth of an accepted count as the bit-period divisor.

Once the block has a divisor, it lets the rest of the sync frame go by without delivering any of it, and then it raises its lock flag. From then on it receives ordinary frames: one low start bit, eight data bits least-significant first, and one and a half high stop bits. It samples each bit at its middle, counting from the falling edge of the start bit. Each good byte comes out with a one-cycle valid strobe. A frame whose stop bit reads low raises a framing-error strobe instead. A synchronous reset discards the lock and the divisor, so the rate is measured again.

The controller has nine states:
- `ST_IDLE`: unlocked, waiting for a falling edge.
- `ST_MEASURE`: counting the low pulse.
- `ST_REJECT`: an over-long pulse was seen; waiting for the line to go high.
- `ST_TAIL`: letting the rest of the sync frame go by.
- `ST_HUNT`: locked, waiting for a start edge.
- `ST_START`: checking the start bit at its middle.
- `ST_DATA`: taking in the eight data bits.
- `ST_STOP`: checking the stop bit at its middle.
- `ST_BREAK`: a framing error was seen; waiting for the line to go high.

The transitions are:
- IDLE→MEASURE on a falling edge.
- MEASURE→TAIL on a rising edge with an in-range count.
- MEASURE→IDLE on a rising edge with a short count.
- MEASURE→REJECT when the count reaches its limit while the line is still low.
- REJECT→IDLE on a high line.
- TAIL→HUNT when the tail timer expires.
- HUNT→START on a falling edge.
- START→HUNT if the line is high at mid-start.
- START→DATA if the line is low at mid-start.
- DATA→STOP after the eighth bit.
- STOP→HUNT on a high stop bit.
- STOP→BREAK on a low stop bit.
- BREAK→HUNT on a high line.

Top module: `autobaud_rx`

## Requirements
- R1: After reset, `locked` is 0, `divisor` is 0 and no strobe fires. A line that stays high changes none of these.
- R2: If the sync low pulse lasts L clocks and is accepted, `divisor` becomes floor(L/8).
- R3: A low pulse shorter than 32 clocks is rejected: `locked` stays 0, `divisor` stays 0, and the block returns to idle, where a later valid sync is accepted.
- R4: A low pulse longer than 4096 clocks is rejected in the same way. A pulse of exactly 4096 clocks is accepted and gives a divisor of 512.
- R5: No part of the sync frame is delivered as data. With D = `divisor` and T = 2*D + floor(D/2), `locked` is still 0 T-1 clocks after the line rises and is 1 by T+5 clocks after it.
- R6: A locked frame is a low start bit, then data bits 0 to 7 in order, then 1.5 high stop bits. A good frame gives exactly one one-cycle `byte_valid` pulse, with the byte on `byte_data`. Frames may follow each other with no idle gap.
- R7: Each bit is sampled half a bit period after its own start, timed from the detected start edge, with the half period rounded to the nearest clock. Reception is correct at every divisor from 4 to 512.
- R8: If the line is low at the middle of the first stop bit, `frame_err` pulses for one cycle and `byte_valid` does not. The block then waits for a high line before it accepts a new start edge.
- R9: If the line is high again at the middle of the start bit, the edge is dropped with no strobe, and the next frame is received normally.
- R10: Asserting `srst` while locked clears `locked` and `divisor`. The next sync character sets a new rate.
- R11: While `locked` stays 1, `divisor` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| locked | output | 1 | Bit rate measured and in force |
| divisor | output | 10 | Bit period in clocks (0 when unlocked) |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte, valid with the strobe |
| frame_err | output | 1 | One-cycle strobe for a low stop bit |

## Verification
Two conditions can meet in the same measurement cycle: the count reaching its upper limit, and the rising edge that ends the pulse. One says reject and the other says accept. The bench provokes this with sync pulses of exactly 4096 and 4097 clocks. The first must lock with divisor 512, and the second must stay unlocked with divisor 0. The bench also sends a synchronous reset into a locked, receiving link, and checks that the lock and the divisor are gone before a new rate is measured.

// File: rtl/abr_pkg.sv
package abr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_REJECT,
        ST_TAIL,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BREAK
    } abr_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/abr_line_sync.sv
module abr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic din,
    output logic lvl,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (srst) chain_q[gi] <= 1'b1;
                    else      chain_q[gi] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (srst) chain_q[gi] <= 1'b1;
                    else      chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (srst) prev_q <= 1'b1;
        else      prev_q <= chain_q[STAGES-1];
    end

    assign lvl  = chain_q[STAGES-1];
    assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/abr_div_calc.sv
module abr_div_calc #(
    parameter int CNT_W      = 13,
    parameter bit ROUND_HALF = 1'b1,
    localparam int DIV_W     = CNT_W - 3,
    localparam int TMR_W     = DIV_W + 2
) (
    input  logic [CNT_W-1:0] count,
    output logic [DIV_W-1:0] div,
    output logic [DIV_W-1:0] half,
    output logic [TMR_W-1:0] tail
);
    assign div = count[CNT_W-1:3];

    generate
        if (ROUND_HALF) begin : g_round
            logic [CNT_W:0] biased;
            assign biased = {1'b0, count} + (CNT_W+1)'(8);
            assign half   = biased[CNT_W:4];
        end else begin : g_trunc
            assign half = {1'b0, count[CNT_W-1:4]};
        end
    endgenerate

    // one data bit plus one and a half stop bits
    assign tail = {1'b0, div, 1'b0} + {3'b000, div[DIV_W-1:1]};
endmodule

// File: rtl/abr_countdown.sv
module abr_countdown #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (srst)              val_q <= '0;
        else if (load)         val_q <= load_val;
        else if (val_q != '0)  val_q <= val_q - 1'b1;
    end

    assign zero = (val_q == '0);
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx
    import abr_pkg::*;
#(
    parameter int MIN_LOW      = 32,
    parameter int MAX_LOW      = 4096,
    parameter int SYNC_STAGES  = 2,
    localparam int CNT_W       = $clog2(MAX_LOW + 1),
    localparam int DIV_W       = CNT_W - 3
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              rxd,
    output logic              locked,
    output logic [DIV_W-1:0]  divisor,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              frame_err
);
    localparam int TMR_W = DIV_W + 2;
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LOW);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LOW);

    abr_state_t state_q, state_d;

    logic              line_lvl, line_fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [DIV_W-1:0]  div_q, half_q;
    logic [DIV_W-1:0]  calc_div, calc_half;
    logic [TMR_W-1:0]  calc_tail;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic [2:0]        bit_idx_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              locked_q, valid_q, ferr_q;
    logic [BYTE_W-1:0] data_q;
    logic              in_range;

    abr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .srst (srst),
        .din  (rxd),
        .lvl  (line_lvl),
        .fall (line_fall)
    );

    abr_div_calc #(.CNT_W(CNT_W), .ROUND_HALF(1'b1)) u_calc (
        .count (cnt_q),
        .div   (calc_div),
        .half  (calc_half),
        .tail  (calc_tail)
    );

    abr_countdown #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .srst     (srst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign in_range = (cnt_q >= CNT_MIN);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (line_fall) state_d = ST_MEASURE;
            ST_MEASURE: begin
                if (line_lvl)               state_d = in_range ? ST_TAIL : ST_IDLE;
                else if (cnt_q == CNT_MAX)  state_d = ST_REJECT;
            end
            ST_REJECT:  if (line_lvl) state_d = ST_IDLE;
            ST_TAIL:    if (tmr_zero) state_d = ST_HUNT;
            ST_HUNT:    if (line_fall) state_d = ST_START;
            ST_START:   if (tmr_zero) state_d = line_lvl ? ST_HUNT : ST_DATA;
            ST_DATA:    if (tmr_zero && bit_idx_q == 3'd7) state_d = ST_STOP;
            ST_STOP:    if (tmr_zero) state_d = line_lvl ? ST_HUNT : ST_BREAK;
            ST_BREAK:   if (line_lvl) state_d = ST_HUNT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // bit timer loads
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_MEASURE: if (line_lvl && in_range) begin
                tmr_load = 1'b1;
                tmr_val  = calc_tail - 1'b1;
            end
            ST_HUNT: if (line_fall) begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(half_q) - 1'b1;
            end
            ST_START, ST_DATA: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(div_q) - 1'b1;
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (srst) state_q <= ST_IDLE;
        else      state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (srst) begin
            cnt_q     <= '0;
            div_q     <= '0;
            half_q    <= '0;
            bit_idx_q <= '0;
            shreg_q   <= '0;
            locked_q  <= 1'b0;
            valid_q   <= 1'b0;
            ferr_q    <= 1'b0;
            data_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (line_fall) cnt_q <= CNT_W'(1);
                ST_MEASURE: begin
                    if (!line_lvl && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    if (line_lvl && in_range) begin
                        div_q  <= calc_div;
                        half_q <= calc_half;
                    end
                end
                ST_TAIL:  if (tmr_zero) locked_q <= 1'b1;
                ST_START: bit_idx_q <= '0;
                ST_DATA: if (tmr_zero) begin
                    shreg_q   <= {line_lvl, shreg_q[BYTE_W-1:1]};
                    bit_idx_q <= bit_idx_q + 1'b1;
                end
                ST_STOP: if (tmr_zero) begin
                    if (line_lvl) begin
                        valid_q <= 1'b1;
                        data_q  <= shreg_q;
                    end else begin
                        ferr_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign locked     = locked_q;
    assign divisor    = div_q;
    assign byte_valid = valid_q;
    assign byte_data  = data_q;
    assign frame_err  = ferr_q;
endmodule

// File: rtl/autobaud_rx_chk.sv
module autobaud_rx_chk #(
    parameter int MIN_LOW = 32,
    parameter int MAX_LOW = 4096,
    parameter int DIV_W   = 10
) (
    input logic             clk,
    input logic             srst,
    input logic             locked,
    input logic [DIV_W-1:0] divisor,
    input logic             byte_valid,
    input logic             frame_err
);
    logic srst_seen_q = 1'b0;

    always_ff @(posedge clk) srst_seen_q <= srst;

    always @(negedge clk) begin
        if (srst_seen_q === 1'b1) begin
            AST_RESET_CLEARS: assert (!locked && divisor == '0 && !byte_valid && !frame_err) else $error("reset did not clear"); // R1
        end
    end

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (srst) byte_valid |-> locked); // R6
    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (srst) !(byte_valid && frame_err)); // R8
    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (srst) locked |-> (divisor >= DIV_W'(MIN_LOW/8) && divisor <= DIV_W'(MAX_LOW/8))); // R4
    AST_DIV_HELD: assert property (@(posedge clk) disable iff (srst) (locked && $past(locked)) |-> $stable(divisor)); // R11
endmodule

bind autobaud_rx autobaud_rx_chk #(
    .MIN_LOW (MIN_LOW),
    .MAX_LOW (MAX_LOW),
    .DIV_W   (DIV_W)
) u_chk (
    .clk        (clk),
    .srst       (srst),
    .locked     (locked),
    .divisor    (divisor),
    .byte_valid (byte_valid),
    .frame_err  (frame_err)
);

// File: tb/autobaud_rx_test.sv
module autobaud_rx_test;
    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       rxd = 1'b1;
    logic       locked;
    logic [9:0] divisor;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       frame_err;

    int total = 0;
    int bad = 0;
    int nvalid = 0;
    int nferr = 0;
    int last_data = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    autobaud_rx uut (
        .clk        (clk),
        .srst       (srst),
        .rxd        (rxd),
        .locked     (locked),
        .divisor    (divisor),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_err  (frame_err)
    );

    always @(negedge clk) begin
        if (byte_valid) begin
            nvalid    = nvalid + 1;
            last_data = byte_data;
        end
        if (frame_err) nferr = nferr + 1;
    end

    // vector table: bit period, sync low length, byte, accept expected
    localparam int NV = 8;
    localparam int VP [NV] = '{4, 16, 16, 100, 512, 4, 512, 8};
    localparam int VL [NV] = '{32, 128, 133, 800, 4096, 31, 4097, 64};
    localparam int VB [NV] = '{8'hA5, 8'h3C, 8'h81, 8'h5A, 8'hC3, 8'h00, 8'h00, 8'h00};
    localparam int VK [NV] = '{1, 1, 1, 1, 1, 0, 0, 1};

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input int n, input logic v);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rxd  = 1'b1;
        srst = 1'b1;
        repeat (3) @(negedge clk);
        srst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input int p, input logic [7:0] b);
        hold(p, 1'b0);
        for (int i = 0; i < 8; i++) hold(p, b[i]);
        hold(p + p / 2, 1'b1);
    endtask

    task automatic sync_lock(input int len, input int p);
        int d;
        d = len / 8;
        hold(len, 1'b0);
        hold(2 * d + d / 2 + 6, 1'b1);
        hold(p, 1'b1);
    endtask

    initial begin
        int base;
        int d;
        int t;
        @(negedge clk);
        @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        chk("R1 locked after reset", int'(locked), 0);
        chk("R1 divisor after reset", int'(divisor), 0);
        hold(1000, 1'b1);
        chk("R1 idle line keeps unlocked", int'(locked), 0);
        chk("R1 no strobe while idle", nvalid + nferr, 0);

        for (int k = 0; k < NV; k++) begin
            do_reset();
            base = nvalid;
            hold(VL[k], 1'b0);
            if (VK[k] != 0) begin
                d = VL[k] / 8;
                t = 2 * d + d / 2;
                hold(t - 1, 1'b1);
                chk("R5 not locked before sync tail ends", int'(locked), 0);
                hold(6, 1'b1);
                chk("R5 locked after sync tail", int'(locked), 1);
                chk("R2 divisor is floor(L/8)", int'(divisor), d);
                hold(2 * VP[k], 1'b1);
                chk("R5 sync frame not delivered", nvalid, base);
                send_byte(VP[k], VB[k][7:0]);
                hold(4, 1'b1);
                chk("R6 one strobe per frame", nvalid, base + 1);
                chk("R7 byte sampled at mid-bit", last_data, VB[k]);
            end else begin
                hold(40, 1'b1);
                chk("R3/R4 out-of-range sync stays unlocked (R3 R4)", int'(locked), 0);
                chk("R4 divisor stays 0 after reject", int'(divisor), 0);
            end
        end

        // R3: reject then recover with a valid sync
        do_reset();
        hold(31, 1'b0);
        hold(20, 1'b1);
        chk("R3 short pulse rejected", int'(locked), 0);
        sync_lock(64, 8);
        chk("R3 later valid sync accepted", int'(locked), 1);
        chk("R3 divisor after recovery", int'(divisor), 8);

        // R6: back-to-back frames, R11 divisor held
        base = nvalid;
        send_byte(8, 8'h12);
        send_byte(8, 8'h34);
        hold(4, 1'b1);
        chk("R6 back-to-back frames both received", nvalid, base + 2);
        chk("R6 last byte of back-to-back pair", last_data, 8'h34);
        chk("R11 divisor unchanged while locked", int'(divisor), 8);

        // R8: framing error
        base = nvalid;
        hold(8, 1'b0);
        for (int i = 0; i < 8; i++) hold(8, i[0]);
        hold(16, 1'b0);
        hold(20, 1'b1);
        chk("R8 framing error strobe", nferr, 1);
        chk("R8 no byte on bad stop", nvalid, base);
        send_byte(8, 8'h6E);
        hold(4, 1'b1);
        chk("R8 reception resumes after error", last_data, 8'h6E);

        // R9: false start
        do_reset();
        sync_lock(128, 16);
        base = nvalid;
        hold(2, 1'b0);
        hold(40, 1'b1);
        chk("R9 glitch gives no byte", nvalid, base);
        chk("R9 glitch gives no error", nferr, 1);
        send_byte(16, 8'h99);
        hold(4, 1'b1);
        chk("R9 next frame received", last_data, 8'h99);

        // R10: synchronous reset while locked
        srst = 1'b1;
        @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        chk("R10 reset clears lock", int'(locked), 0);
        chk("R10 reset clears divisor", int'(divisor), 0);
        sync_lock(32, 4);
        chk("R10 new rate measured", int'(divisor), 4);
        send_byte(4, 8'hE7);
        hold(4, 1'b1);
        chk("R10 byte at new rate", last_data, 8'hE7);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule